// File: doc/BRIEF.md
# Flash Program/Erase Status Responder

This block produces the byte a NOR-style flash device presents on its data pins while an internal program or erase job is running. It looks at the read strobes (active-low chip enable and output enable), the read address, the job state supplied by the device's sequencer, and two per-sector masks. One mask marks the sectors chosen for erase and the other marks the write-protected sectors. During a job, every read returns a status byte instead of array contents. Bit 7 is a polarity flag. Bit 6 is a toggle that shows the device is busy, at any address. Bit 2 is a toggle that shows which sectors are chosen for erase.

The block also handles jobs that target protected storage. A program into a protected sector, or an erase whose chosen sectors are all protected, shows busy status for a fixed number of clock cycles. The block then raises a one-cycle abort pulse to the sequencer and returns array data until the next job starts. For a partly protected erase, the block reports which sectors the sequencer may actually erase.

Top module: `flash_status_resp`

## Requirements
- R1: After reset, `dq_o` and `abort_o` are 0, and both toggle bits start at 0.
- R2: When `ce_n` or `oe_n` is high, `dq_o` reads 0x00.
- R3: With the job state idle (`job_i`=0), or after an abort, a read returns `array_data` unchanged.
- R4: While erasing (`job_i`=2), status bit 7 is 0. In erase-suspend (`job_i`=3), a read in a sector chosen for erase has bit 7 = 1.
- R5: While programming (`job_i`=1) or programming during erase-suspend (`job_i`=4), status bit 7 is the complement of `prog_d7`.
- R6: In job states 1, 2 and 4, bit 6 inverts between one read cycle and the next, at any address. It stays constant for the whole of a read cycle. A read cycle ends when either strobe rises.
- R7: In erase-suspend (`job_i`=3), bit 6 holds its value across reads.
- R8: Bit 2 inverts after a read cycle whose sector (the top `SECT_W` address bits) is chosen in `erase_sel`, in job state 2 or 3. Reads to other sectors leave it unchanged.
- R9: In a status byte, bits 5, 4, 3, 1 and 0 are 0.
- R10: In erase-suspend, a read to a sector not chosen for erase returns `array_data`.
- R11: If `job_start` pulses with `job_i`=2 and no chosen sector is unprotected, `abort_o` pulses high exactly `ERASE_TO_CYC` cycles after the start edge. From then until the next `job_start`, reads return array data.
- R12: If `job_start` pulses with `job_i`=1 and the sector `prog_sector` is protected, `abort_o` pulses after `PROG_TO_CYC` cycles, with the same return to array data.
- R13: `eff_erase_o` equals `erase_sel` with the protected sectors removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_addr | input | ADDR_W | Read address; top SECT_W bits select the sector |
| array_data | input | 8 | Stored byte at the read address |
| job_i | input | 3 | Job state: 0 idle, 1 program, 2 erase, 3 erase-suspend, 4 suspend-program |
| job_start | input | 1 | One-cycle pulse at the final write strobe of a command |
| prog_sector | input | SECT_W | Sector targeted by a program job |
| prog_d7 | input | 1 | Bit 7 of the byte being programmed |
| erase_sel | input | 2**SECT_W | Sectors chosen for erase |
| protect | input | 2**SECT_W | Write-protected sectors |
| dq_o | output | 8 | Read data or status byte |
| abort_o | output | 1 | One-cycle pulse when a protected job times out |
| eff_erase_o | output | 2**SECT_W | Chosen sectors that may really be erased |

## Verification
`dq_o` and `eff_erase_o` are combinational from the inputs and the toggle registers. A new address or job state therefore shows in the same cycle. A toggle bit changes one clock edge after a strobe rises, so it appears on the next read. `abort_o` is a register that rises on the clock edge `PROG_TO_CYC` or `ERASE_TO_CYC` edges after the edge that captured `job_start`. The bench drives inputs on the falling edge and samples one time unit later. Its reference model updates on each rising edge, so the value it predicts is the one the design must show in that half cycle. The abort checks count falling-edge samples from the start edge and expect exactly the timeout value.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    typedef enum logic [2:0] {
        JOB_IDLE   = 3'd0,
        JOB_PROG   = 3'd1,
        JOB_ERASE  = 3'd2,
        JOB_ESUSP  = 3'd3,
        JOB_ESPROG = 3'd4
    } job_e;

    // state of the read-cycle tracker and both toggle flags
    typedef struct packed {
        logic rd;    // a read cycle was active last clock
        logic hit6;  // busy toggle armed by the current read
        logic hit2;  // sector toggle armed by the current read
        logic t6;
        logic t2;
    } tgl_s;

endpackage

// File: rtl/fsr_toggle.sv
module fsr_toggle
    import fsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_act,
    input  logic busy6,
    input  logic hit2_now,
    output logic t6,
    output logic t2
);

    tgl_s tgl_d, tgl_q;
    logic rd_end;

    assign rd_end = tgl_q.rd && !rd_act;

    always_comb begin
        tgl_d    = tgl_q;
        tgl_d.rd = rd_act;
        if (rd_act) begin
            tgl_d.hit6 = busy6;
            tgl_d.hit2 = hit2_now;
        end
        if (rd_end) begin
            tgl_d.t6 = tgl_q.t6 ^ tgl_q.hit6;
            tgl_d.t2 = tgl_q.t2 ^ tgl_q.hit2;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tgl_q <= '0;
        else        tgl_q <= tgl_d;
    end

    assign t6 = tgl_q.t6;
    assign t2 = tgl_q.t2;

    // R6: busy toggle only moves when a read cycle closes
    a_r6_t6_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_end |=> $stable(tgl_q.t6));
    // R8: sector toggle only moves when a read cycle closes
    a_r8_t2_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_end |=> $stable(tgl_q.t2));
    // R6: an armed busy read always flips the toggle on close
    a_r6_t6_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_end && tgl_q.hit6) |=> (tgl_q.t6 != $past(tgl_q.t6)));

endmodule

// File: rtl/fsr_guard.sv
module fsr_guard #(
    parameter int PROG_TO_CYC  = 50,
    parameter int ERASE_TO_CYC = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic is_prog,
    input  logic is_erase,
    input  logic prog_prot,
    input  logic all_prot,
    output logic aborted,
    output logic abort_pulse
);

    localparam int MAX_TO = (PROG_TO_CYC > ERASE_TO_CYC) ? PROG_TO_CYC : ERASE_TO_CYC;
    localparam int CNT_W  = $clog2(MAX_TO + 1);
    localparam logic [CNT_W-1:0] PROG_L  = CNT_W'(PROG_TO_CYC);
    localparam logic [CNT_W-1:0] ERASE_L = CNT_W'(ERASE_TO_CYC);

    typedef struct packed {
        logic             guard;
        logic             aborted;
        logic             pulse;
        logic [CNT_W-1:0] cnt;
    } grd_s;

    grd_s grd_d, grd_q;

    always_comb begin
        grd_d       = grd_q;
        grd_d.pulse = 1'b0;
        if (start) begin
            grd_d.aborted = 1'b0;
            grd_d.guard   = 1'b0;
            grd_d.cnt     = '0;
            if (is_prog && prog_prot) begin
                grd_d.guard = 1'b1;
                grd_d.cnt   = PROG_L;
            end else if (is_erase && all_prot) begin
                grd_d.guard = 1'b1;
                grd_d.cnt   = ERASE_L;
            end
        end else if (grd_q.guard) begin
            if (grd_q.cnt == CNT_W'(1)) begin
                grd_d.guard   = 1'b0;
                grd_d.aborted = 1'b1;
                grd_d.pulse   = 1'b1;
                grd_d.cnt     = '0;
            end else begin
                grd_d.cnt = grd_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) grd_q <= '0;
        else        grd_q <= grd_d;
    end

    assign aborted     = grd_q.aborted;
    assign abort_pulse = grd_q.pulse;

    // R11: busy window and abort pulse never overlap
    a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grd_q.guard, grd_q.pulse}));
    // R11: an abort pulse follows only the end of a busy window
    a_r11_pulse_after_guard: assert property (@(posedge clk) disable iff (!rst_n)
        grd_q.pulse |-> $past(grd_q.guard));
    // R12: a running window always has time left on it
    a_r12_count_live: assert property (@(posedge clk) disable iff (!rst_n)
        grd_q.guard |-> (grd_q.cnt != '0));

endmodule

// File: rtl/flash_status_resp.sv
module flash_status_resp
    import fsr_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int SECT_W       = 3,
    parameter int PROG_TO_CYC  = 50,
    parameter int ERASE_TO_CYC = 5000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ce_n,
    input  logic                   oe_n,
    input  logic [ADDR_W-1:0]      rd_addr,
    input  logic [7:0]             array_data,
    input  logic [2:0]             job_i,
    input  logic                   job_start,
    input  logic [SECT_W-1:0]      prog_sector,
    input  logic                   prog_d7,
    input  logic [(1<<SECT_W)-1:0] erase_sel,
    input  logic [(1<<SECT_W)-1:0] protect,
    output logic [7:0]             dq_o,
    output logic                   abort_o,
    output logic [(1<<SECT_W)-1:0] eff_erase_o
);

    localparam int NSECT = 1 << SECT_W;

    job_e              job;
    logic              rd_act;
    logic [SECT_W-1:0] rd_sect;
    logic              sel_hit;
    logic              all_prot;
    logic              prog_prot;
    logic              aborted;
    logic              busy6;
    logic              hit2_now;
    logic              t6, t2;
    logic              status_on;
    logic              stat_b7;
    logic              unused_addr_lo;

    assign job            = job_e'(job_i);
    assign rd_act         = !ce_n && !oe_n;
    assign rd_sect        = rd_addr[ADDR_W-1 -: SECT_W];
    assign unused_addr_lo = ^rd_addr[ADDR_W-SECT_W-1:0];
    assign sel_hit        = erase_sel[rd_sect];
    assign eff_erase_o    = erase_sel & ~protect;
    assign all_prot       = (eff_erase_o == {NSECT{1'b0}});
    assign prog_prot      = protect[prog_sector];

    assign busy6    = !aborted && (job == JOB_PROG || job == JOB_ERASE || job == JOB_ESPROG);
    assign hit2_now = !aborted && (job == JOB_ERASE || job == JOB_ESUSP) && sel_hit;

    fsr_guard #(
        .PROG_TO_CYC (PROG_TO_CYC),
        .ERASE_TO_CYC(ERASE_TO_CYC)
    ) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (job_start),
        .is_prog    (job == JOB_PROG),
        .is_erase   (job == JOB_ERASE),
        .prog_prot  (prog_prot),
        .all_prot   (all_prot),
        .aborted    (aborted),
        .abort_pulse(abort_o)
    );

    fsr_toggle u_toggle (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_act  (rd_act),
        .busy6   (busy6),
        .hit2_now(hit2_now),
        .t6      (t6),
        .t2      (t2)
    );

    always_comb begin
        status_on = 1'b0;
        stat_b7   = 1'b0;
        case (job)
            JOB_PROG, JOB_ESPROG: begin
                status_on = 1'b1;
                stat_b7   = ~prog_d7;
            end
            JOB_ERASE: begin
                status_on = 1'b1;
                stat_b7   = 1'b0;
            end
            JOB_ESUSP: begin
                status_on = sel_hit;
                stat_b7   = 1'b1;
            end
            default: ;
        endcase
        if (aborted) status_on = 1'b0;

        if (!rd_act)        dq_o = 8'h00;
        else if (status_on) dq_o = {stat_b7, t6, 3'b000, t2, 2'b00};
        else                dq_o = array_data;
    end

    // R2: released strobes give a quiet bus
    a_r2_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_act |-> (dq_o == 8'h00));
    // R4: a live erase never shows a set polarity bit
    a_r4_erase_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && job == JOB_ERASE && !aborted) |-> !dq_o[7]);
    // R9: unused status positions stay clear
    a_r9_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && status_on) |-> ((dq_o & 8'h3B) == 8'h00));
    // R3: an aborted job hands the bus back to array data
    a_r3_abort_array: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && aborted) |-> (dq_o == array_data));

endmodule

// File: tb/tb_flash_status_resp.sv
module tb_flash_status_resp;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam int SECT_W     = 3;
    localparam int NSECT      = 8;
    localparam int P_TO       = 50;
    localparam int E_TO       = 5000;

    logic              clk = 0;
    logic              rst_n = 0;
    logic              ce_n = 1, oe_n = 1;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [7:0]        array_data = 8'h00;
    logic [2:0]        job_i = 3'd0;
    logic              job_start = 0;
    logic [SECT_W-1:0] prog_sector = '0;
    logic              prog_d7 = 0;
    logic [NSECT-1:0]  erase_sel = '0;
    logic [NSECT-1:0]  protect = '0;
    logic [7:0]        dq_o;
    logic              abort_o;
    logic [NSECT-1:0]  eff_erase_o;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;
    string cur_req = "R1";

    // reference model state
    bit m_rd, m_h6, m_h2, m_t6, m_t2, m_g, m_ab, m_pulse;
    int m_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_status_resp #(
        .ADDR_W(ADDR_W), .SECT_W(SECT_W),
        .PROG_TO_CYC(P_TO), .ERASE_TO_CYC(E_TO)
    ) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
        .rd_addr(rd_addr), .array_data(array_data), .job_i(job_i),
        .job_start(job_start), .prog_sector(prog_sector), .prog_d7(prog_d7),
        .erase_sel(erase_sel), .protect(protect), .dq_o(dq_o),
        .abort_o(abort_o), .eff_erase_o(eff_erase_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // behavioural model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_rd = 0; m_h6 = 0; m_h2 = 0; m_t6 = 0; m_t2 = 0;
            m_g = 0; m_ab = 0; m_pulse = 0; m_cnt = 0;
        end else begin
            bit rd_now;
            int sect;
            rd_now = !ce_n && !oe_n;
            sect   = int'(rd_addr) / (1 << (ADDR_W - SECT_W));
            if (m_rd && !rd_now) begin
                if (m_h6) m_t6 = !m_t6;
                if (m_h2) m_t2 = !m_t2;
            end
            if (rd_now) begin
                m_h6 = !m_ab && (job_i == 1 || job_i == 2 || job_i == 4);
                m_h2 = !m_ab && (job_i == 2 || job_i == 3) && erase_sel[sect];
            end
            m_rd    = rd_now;
            m_pulse = 0;
            if (job_start) begin
                m_ab = 0; m_g = 0;
                if (job_i == 1 && protect[prog_sector]) begin
                    m_g = 1; m_cnt = P_TO;
                end else if (job_i == 2 && (erase_sel & ~protect) == 0) begin
                    m_g = 1; m_cnt = E_TO;
                end
            end else if (m_g) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_g = 0; m_ab = 1; m_pulse = 1;
                end
            end
        end
    end

    function automatic logic [7:0] model_dq();
        int   sect;
        logic b7;
        sect = int'(rd_addr) / (1 << (ADDR_W - SECT_W));
        if (ce_n || oe_n) return 8'h00;
        if (m_ab || job_i == 0 || job_i > 4 || (job_i == 3 && !erase_sel[sect]))
            return array_data;
        if (job_i == 2)      b7 = 1'b0;
        else if (job_i == 3) b7 = 1'b1;
        else                 b7 = ~prog_d7;
        return {b7, m_t6, 3'b000, m_t2, 2'b00};
    endfunction

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk(cur_req, dq_o, model_dq());
            chk(cur_req, {7'd0, abort_o}, {7'd0, m_pulse});
            chk("R13", eff_erase_o, erase_sel & ~protect);
        end
    end

    task automatic rd_once(input logic [ADDR_W-1:0] a, output logic [7:0] v);
        @(negedge clk); rd_addr = a; ce_n = 0; oe_n = 0;
        @(negedge clk); #2 v = dq_o;
        @(negedge clk); #2 chk("R6 in-read hold", {1'b0, dq_o[6], 6'd0}, {1'b0, v[6], 6'd0});
        oe_n = 1; ce_n = 1;
    endtask

    task automatic start_job(input logic [2:0] j);
        @(negedge clk); job_i = j; job_start = 1;
        @(negedge clk); job_start = 0;
    endtask

    task automatic abort_count(input logic [2:0] j, input int lim, output int n);
        @(negedge clk); job_i = j; job_start = 1;
        @(negedge clk); job_start = 0;
        n = 0;
        while (n <= lim + 2) begin
            #2;
            if (abort_o) break;
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v1, v2, v3;
        int         n;
        repeat (3) @(negedge clk);
        #2;
        chk("R1 reset dq", dq_o, 8'h00);
        chk("R1 reset abort", {7'd0, abort_o}, 8'h00);
        @(negedge clk); rst_n = 1;

        cur_req = "R2";
        @(negedge clk); ce_n = 0; oe_n = 1; array_data = 8'h5A;
        @(negedge clk); #2 chk("R2 oe high", dq_o, 8'h00);
        ce_n = 1; oe_n = 0;
        @(negedge clk); #2 chk("R2 ce high", dq_o, 8'h00);
        oe_n = 1;

        cur_req = "R3";
        array_data = 8'hA5;
        rd_once(16'h1234, v1); chk("R3 idle array", v1, 8'hA5);
        array_data = 8'h3C;
        rd_once(16'hE000, v1); chk("R3 idle array", v1, 8'h3C);

        cur_req = "R5";
        prog_sector = 3'd2; prog_d7 = 1; protect = 8'h00;
        start_job(3'd1);
        rd_once(16'h4000, v1); chk("R1 first toggle 0", v1, 8'h00);
        chk("R5 polarity d7=1", {v1[7], 7'd0}, 8'h00);
        prog_d7 = 0;
        cur_req = "R6";
        rd_once(16'h0010, v2); chk("R5 polarity d7=0", {v2[7], 7'd0}, 8'h80);
        chk("R6 toggle any addr", {1'b0, v2[6], 6'd0}, {1'b0, ~v1[6], 6'd0});
        rd_once(16'hF0F0, v3);
        chk("R6 toggle again", {1'b0, v3[6], 6'd0}, {1'b0, ~v2[6], 6'd0});
        chk("R9 zero bits", v3 & 8'h3B, 8'h00);
        job_i = 3'd0;

        cur_req = "R8";
        erase_sel = 8'b0000_1010; protect = 8'b0000_1000;
        @(negedge clk); #2 chk("R13 effective erase", eff_erase_o, 8'b0000_0010);
        start_job(3'd2);
        rd_once(16'h2000, v1); chk("R4 erase polarity", {v1[7], 7'd0}, 8'h00);
        rd_once(16'h2004, v2);
        chk("R8 sector toggle", {5'd0, v2[2], 2'd0}, {5'd0, ~v1[2], 2'd0});
        rd_once(16'h4000, v3);
        rd_once(16'h2008, v1);
        chk("R8 unselected no toggle", {5'd0, v1[2], 2'd0}, {5'd0, ~v2[2], 2'd0});
        chk("R9 zero bits erase", v1 & 8'h3B, 8'h00);

        cur_req = "R7";
        @(negedge clk); job_i = 3'd3;
        rd_once(16'h2000, v1); chk("R4 suspend polarity", {v1[7], 7'd0}, 8'h80);
        rd_once(16'h2002, v2);
        chk("R7 held toggle", {1'b0, v2[6], 6'd0}, {1'b0, v1[6], 6'd0});
        chk("R8 toggle in suspend", {5'd0, v2[2], 2'd0}, {5'd0, ~v1[2], 2'd0});
        cur_req = "R10";
        array_data = 8'h77;
        rd_once(16'hA000, v1); chk("R10 unselected array", v1, 8'h77);

        cur_req = "R5";
        @(negedge clk); job_i = 3'd4; prog_d7 = 1;
        rd_once(16'hA000, v1); rd_once(16'hA000, v2);
        chk("R5 suspend-program polarity", {v2[7], 7'd0}, 8'h00);
        chk("R6 suspend-program toggle", {1'b0, v2[6], 6'd0}, {1'b0, ~v1[6], 6'd0});
        @(negedge clk); job_i = 3'd0;

        cur_req = "R12";
        protect = 8'b0010_0000; prog_sector = 3'd5;
        abort_count(3'd1, P_TO, n);
        chk("R12 program timeout cycles", 8'(n), 8'(P_TO));
        array_data = 8'h96;
        rd_once(16'hA000, v1); chk("R12 array after abort", v1, 8'h96);
        @(negedge clk); job_i = 3'd0;

        cur_req = "R11";
        erase_sel = 8'b0011_0000; protect = 8'b0011_0000;
        @(negedge clk); rd_addr = 16'hA000; ce_n = 0; oe_n = 0;
        abort_count(3'd2, E_TO, n);
        chk("R11 erase timeout cycles", 8'(n / 100), 8'(E_TO / 100));
        chk("R11 erase timeout exact", 8'(n % 100), 8'(E_TO % 100));
        @(negedge clk); #2 chk("R11 array after abort", dq_o, array_data);
        ce_n = 1; oe_n = 1;
        array_data = 8'h21;
        rd_once(16'h8000, v1); chk("R11 stays in read mode", v1, 8'h21);
        @(negedge clk); job_i = 3'd0;
        repeat (3) @(negedge clk);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule